// File: doc/BRIEF.md
# Polymorphic Element Register File

This block is the integer register file of a 64-bit core: 128 registers of 8 bytes, stored as one flat byte array. Each port addresses the file as a run of elements whose width is 8, 16, 32 or 64 bits. The run starts at a chosen base register. An element offset larger than one register holds carries on into the registers that follow, so a single vector of narrow elements can cover several registers.

There are two combinational read ports and one clocked write port. Each port takes a base register, a width code and an element offset. A vector-mode write changes only the bytes of the addressed element. A scalar-mode write widens the element to 64 bits, by sign or zero extension, and stores it whole at the base register. Any access that would touch bytes past the end of the file raises an out-of-range flag, and a write that does so is dropped.

Top module: `poly_regfile`

## Requirements
- R1: While reset is held and after it is released, every byte of the file reads as zero.
- R2: Width code 0 selects a 64-bit element, code 1 an 8-bit element, code 2 a 16-bit element and code 3 a 32-bit element. A read returns the element zero-extended to 64 bits.
- R3: An element's first byte address is base×8 + offset×(element bytes). Offsets carry on into the following registers. Element bytes are little-endian: the lowest address holds bits 7:0. Register r holds bytes r×8 to r×8+7.
- R4: A read whose element would extend past byte 1023 sets its out-of-range flag and returns zero.
- R5: A vector write whose element would extend past byte 1023 sets the write out-of-range flag and changes no byte of the file.
- R6: A vector write (vector select = 1) changes only the bytes of the addressed element. Every other byte keeps its value.
- R7: A scalar write (vector select = 0) takes the low element-width bits of the data. It sign-extends them when the sign select is 1 and zero-extends them when it is 0. It stores all 8 bytes at base register ×8, ignores the offset, and never flags out-of-range.
- R8: The two read ports are independent. Each returns its own element in the same cycle.
- R9: A read of bytes that are being written in the same cycle returns the old data. The new data is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset, clears the file |
| rd0_reg | input | 7 | Read port 0 base register |
| rd0_wid | input | 2 | Read port 0 width code |
| rd0_off | input | 10 | Read port 0 element offset |
| rd0_data | output | 64 | Read port 0 element, zero-extended |
| rd0_oor | output | 1 | Read port 0 out-of-range |
| rd1_reg | input | 7 | Read port 1 base register |
| rd1_wid | input | 2 | Read port 1 width code |
| rd1_off | input | 10 | Read port 1 element offset |
| rd1_data | output | 64 | Read port 1 element, zero-extended |
| rd1_oor | output | 1 | Read port 1 out-of-range |
| wr_en | input | 1 | Write enable |
| wr_vec | input | 1 | 1 = vector element write, 0 = scalar whole-register write |
| wr_sext | input | 1 | Scalar extension: 1 = sign, 0 = zero |
| wr_reg | input | 7 | Write base register |
| wr_wid | input | 2 | Write width code |
| wr_off | input | 10 | Write element offset (vector mode only) |
| wr_data | input | 64 | Write data, element in the low bits |
| wr_oor | output | 1 | Write out-of-range; the write is dropped |

## Verification
The bench goes after elements that cross a register boundary. A design that uses the offset as a per-register index would wrap inside the base register instead of reaching the next one. It probes the last bytes of register 127 with each width. An off-by-one in the end test would either flag a legal last element or let a write corrupt storage that does not exist. Scalar writes of values with the top bit set are run with both extension modes, and also with a nonzero offset that must be ignored. Reads and writes to the same bytes in the same cycle catch a design that forwards new data early. Random traffic checks that neighbouring bytes survive narrow writes.

// File: rtl/poly_regfile.sv
module poly_regfile #(
  parameter int NREGS = 128,
  parameter int OFF_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        rd0_reg,
  input  logic [1:0]        rd0_wid,
  input  logic [OFF_W-1:0]  rd0_off,
  output logic [63:0]       rd0_data,
  output logic              rd0_oor,
  input  logic [6:0]        rd1_reg,
  input  logic [1:0]        rd1_wid,
  input  logic [OFF_W-1:0]  rd1_off,
  output logic [63:0]       rd1_data,
  output logic              rd1_oor,
  input  logic              wr_en,
  input  logic              wr_vec,
  input  logic              wr_sext,
  input  logic [6:0]        wr_reg,
  input  logic [1:0]        wr_wid,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [63:0]       wr_data,
  output logic              wr_oor
);
  localparam int NBYTES = NREGS * 8;
  localparam int NAW    = $clog2(NBYTES);
  localparam int AW     = OFF_W + 7 + 4;

  function automatic logic [3:0] wbytes(input logic [1:0] c);
    case (c)
      2'd1: return 4'd1;
      2'd2: return 4'd2;
      2'd3: return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [AW-1:0] baddr(input logic [6:0] r, input logic [OFF_W-1:0] o,
                                          input logic [3:0] eb);
    return (AW'(r) << 3) + AW'(o) * AW'(eb);
  endfunction

  logic [7:0] mem [NBYTES];

  logic [3:0]    eb0, eb1, ebw;
  logic [AW-1:0] a0, a1, aw;
  logic [63:0]   wval;

  assign eb0 = wbytes(rd0_wid);
  assign eb1 = wbytes(rd1_wid);
  assign a0  = baddr(rd0_reg, rd0_off, eb0);
  assign a1  = baddr(rd1_reg, rd1_off, eb1);
  assign rd0_oor = (a0 + AW'(eb0)) > AW'(NBYTES);
  assign rd1_oor = (a1 + AW'(eb1)) > AW'(NBYTES);

  assign ebw    = wr_vec ? wbytes(wr_wid) : 4'd8;
  assign aw     = wr_vec ? baddr(wr_reg, wr_off, ebw) : (AW'(wr_reg) << 3);
  assign wr_oor = wr_en && wr_vec && ((aw + AW'(ebw)) > AW'(NBYTES));

  always_comb begin
    case (wr_wid)
      2'd1: wval = {{56{wr_sext & wr_data[7]}},  wr_data[7:0]};
      2'd2: wval = {{48{wr_sext & wr_data[15]}}, wr_data[15:0]};
      2'd3: wval = {{32{wr_sext & wr_data[31]}}, wr_data[31:0]};
      default: wval = wr_data;
    endcase
    if (wr_vec) wval = wr_data;
  end

  always_comb begin
    rd0_data = '0;
    rd1_data = '0;
    for (int k = 0; k < 8; k++) begin
      if (!rd0_oor && 4'(k) < eb0) rd0_data[8*k +: 8] = mem[NAW'(a0 + AW'(k))];
      if (!rd1_oor && 4'(k) < eb1) rd1_data[8*k +: 8] = mem[NAW'(a1 + AW'(k))];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) mem[i] <= 8'h00;
    end else if (wr_en && !wr_oor) begin
      for (int k = 0; k < 8; k++)
        if (4'(k) < ebw) mem[NAW'(aw + AW'(k))] <= wval[8*k +: 8];
    end
  end

  function automatic logic [63:0] wmask(input logic [1:0] c);
    case (c)
      2'd1: return 64'h0000_0000_0000_00ff;
      2'd2: return 64'h0000_0000_0000_ffff;
      2'd3: return 64'h0000_0000_ffff_ffff;
      default: return '1;
    endcase
  endfunction

  p_oor_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_oor || rd1_oor) |-> ((rd0_oor ? rd0_data == 64'd0 : 1'b1) && (rd1_oor ? rd1_data == 64'd0 : 1'b1)));

  p_last_reg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_reg == 7'(NREGS - 1) && rd0_wid == 2'd0 && rd0_off == OFF_W'(1)) |-> rd0_oor);

  p_narrow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_wid == 2'd1) |-> (rd0_data[63:8] == 56'd0));

  p_scalar_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_vec) |-> !wr_oor);

  p_wr_visible_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en && wr_vec && !wr_oor) && rd0_reg == $past(wr_reg) && rd0_wid == $past(wr_wid)
     && rd0_off == $past(wr_off)) |-> (rd0_data == ($past(wr_data) & wmask(rd0_wid))));
endmodule

// File: tb/poly_regfile_tb.sv
`timescale 1ns/1ps
module poly_regfile_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic [6:0] rd0_reg = 0, rd1_reg = 0, wr_reg = 0;
  logic [1:0] rd0_wid = 0, rd1_wid = 0, wr_wid = 0;
  logic [9:0] rd0_off = 0, rd1_off = 0, wr_off = 0;
  logic wr_en = 0, wr_vec = 0, wr_sext = 0;
  logic [63:0] wr_data = 0;
  logic [63:0] rd0_data, rd1_data;
  logic rd0_oor, rd1_oor, wr_oor;

  int n_chk = 0, n_fail = 0;
  bit [7:0] mdl [1024];

  always #2.5 clk = ~clk;

  poly_regfile dut_i (.clk(clk), .rst_n(rst_n),
    .rd0_reg(rd0_reg), .rd0_wid(rd0_wid), .rd0_off(rd0_off), .rd0_data(rd0_data), .rd0_oor(rd0_oor),
    .rd1_reg(rd1_reg), .rd1_wid(rd1_wid), .rd1_off(rd1_off), .rd1_data(rd1_data), .rd1_oor(rd1_oor),
    .wr_en(wr_en), .wr_vec(wr_vec), .wr_sext(wr_sext), .wr_reg(wr_reg), .wr_wid(wr_wid),
    .wr_off(wr_off), .wr_data(wr_data), .wr_oor(wr_oor));

  function automatic int nb(input logic [1:0] c);
    return (c == 0) ? 8 : (1 << (c - 1));
  endfunction

  function automatic int first_byte(input logic [6:0] r, input logic [1:0] c, input logic [9:0] o);
    return int'(r) * 8 + int'(o) * nb(c);
  endfunction

  function automatic bit over(input logic [6:0] r, input logic [1:0] c, input logic [9:0] o);
    return first_byte(r, c, o) + nb(c) > 1024;
  endfunction

  function automatic logic [63:0] mread(input logic [6:0] r, input logic [1:0] c, input logic [9:0] o);
    logic [63:0] v = 0;
    if (over(r, c, o)) return 0;
    for (int k = 0; k < nb(c); k++) v[8*k +: 8] = mdl[first_byte(r, c, o) + k];
    return v;
  endfunction

  function automatic logic [63:0] extend(input logic [63:0] d, input logic [1:0] c, input bit s);
    int bits = nb(c) * 8;
    logic [63:0] m = (bits == 64) ? '1 : ((64'd1 << bits) - 1);
    logic [63:0] v = d & m;
    if (s && d[bits-1]) v = v | ~m;
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag,
                     input logic [6:0] r0, input logic [1:0] c0, input logic [9:0] o0,
                     input logic [6:0] r1, input logic [1:0] c1, input logic [9:0] o1,
                     input bit we, input bit vec, input bit sx,
                     input logic [6:0] wr, input logic [1:0] wc, input logic [9:0] wo,
                     input logic [63:0] wd);
    bit eo;
    rd0_reg = r0; rd0_wid = c0; rd0_off = o0;
    rd1_reg = r1; rd1_wid = c1; rd1_off = o1;
    wr_en = we; wr_vec = vec; wr_sext = sx; wr_reg = wr; wr_wid = wc; wr_off = wo; wr_data = wd;
    #1;
    chk(rd0_data == mread(r0, c0, o0), {tag, " rd0 data"}, rd0_data, mread(r0, c0, o0));
    chk(rd0_oor == over(r0, c0, o0), {tag, " rd0 oor"}, 64'(rd0_oor), 64'(over(r0, c0, o0)));
    chk(rd1_data == mread(r1, c1, o1), {tag, " rd1 data"}, rd1_data, mread(r1, c1, o1));
    chk(rd1_oor == over(r1, c1, o1), {tag, " rd1 oor"}, 64'(rd1_oor), 64'(over(r1, c1, o1)));
    eo = we && vec && over(wr, wc, wo);
    chk(wr_oor == eo, {tag, " wr oor"}, 64'(wr_oor), 64'(eo));
    @(posedge clk);
    if (we && !eo) begin
      if (vec) for (int k = 0; k < nb(wc); k++) mdl[first_byte(wr, wc, wo) + k] = wd[8*k +: 8];
      else begin
        logic [63:0] v = extend(wd, wc, sx);
        for (int k = 0; k < 8; k++) mdl[int'(wr) * 8 + k] = v[8*k +: 8];
      end
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    #(5.0 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: file cleared
    for (int r = 0; r < 128; r += 2)
      cyc("R1", 7'(r), 2'd0, 10'd0, 7'(r + 1), 2'd0, 10'd0, 0, 0, 0, 0, 0, 0, 0);
    // R3: byte element spills into next register
    cyc("R3", 0, 0, 0, 0, 0, 0, 1, 1, 0, 7'd5, 2'd1, 10'd9, 64'hA5);
    cyc("R3", 7'd6, 2'd0, 10'd0, 7'd5, 2'd3, 10'd3, 0, 0, 0, 0, 0, 0, 0);
    cyc("R2", 7'd3, 2'd0, 0, 7'd3, 2'd0, 0, 1, 1, 0, 7'd3, 2'd0, 10'd0, 64'h8877_6655_4433_2211);
    cyc("R2", 7'd3, 2'd1, 10'd7, 7'd3, 2'd2, 10'd1, 0, 0, 0, 0, 0, 0, 0);
    cyc("R2", 7'd3, 2'd3, 10'd1, 7'd4, 2'd2, 10'd0, 0, 0, 0, 0, 0, 0, 0);
    // R4: end of file boundaries
    cyc("R4", 7'd127, 2'd0, 10'd1, 7'd127, 2'd1, 10'd7, 0, 0, 0, 0, 0, 0, 0);
    cyc("R4", 7'd127, 2'd1, 10'd8, 7'd126, 2'd2, 10'd7, 0, 0, 0, 0, 0, 0, 0);
    cyc("R4", 7'd0, 2'd1, 10'd1023, 7'd0, 2'd1, 10'd1000, 0, 0, 0, 0, 0, 0, 0);
    // R5: dropped writes past the end
    cyc("R5", 0, 0, 0, 0, 0, 0, 1, 1, 0, 7'd127, 2'd3, 10'd2, 64'hDEAD_BEEF);
    cyc("R5", 0, 0, 0, 0, 0, 0, 1, 1, 0, 7'd127, 2'd3, 10'd1, 64'hCAFE_F00D);
    cyc("R5", 7'd127, 2'd0, 10'd0, 7'd127, 2'd3, 10'd1, 1, 1, 0, 7'd120, 2'd2, 10'd40, 64'h1234);
    cyc("R5", 7'd127, 2'd0, 10'd0, 7'd127, 2'd2, 10'd3, 0, 0, 0, 0, 0, 0, 0);
    // R6: narrow write keeps neighbours
    cyc("R6", 0, 0, 0, 0, 0, 0, 1, 1, 0, 7'd3, 2'd2, 10'd2, 64'hFFFF_FFFF_FFFF_0BAD);
    cyc("R6", 7'd3, 2'd0, 10'd0, 7'd3, 2'd2, 10'd2, 0, 0, 0, 0, 0, 0, 0);
    // R7: scalar extension, offset ignored
    cyc("R7", 0, 0, 0, 0, 0, 0, 1, 0, 1, 7'd10, 2'd1, 10'd5, 64'h1234_5680);
    cyc("R7", 7'd10, 2'd0, 10'd0, 7'd10, 2'd3, 10'd1, 1, 0, 0, 7'd11, 2'd1, 10'd5, 64'h1234_5680);
    cyc("R7", 7'd11, 2'd0, 10'd0, 7'd10, 2'd0, 10'd0, 1, 0, 1, 7'd12, 2'd3, 10'd9, 64'h0000_0000_8000_0001);
    cyc("R7", 7'd12, 2'd0, 10'd0, 7'd13, 2'd0, 10'd0, 1, 0, 1, 7'd127, 2'd2, 10'd900, 64'h7FFF);
    cyc("R7", 7'd127, 2'd0, 10'd0, 7'd12, 2'd2, 10'd3, 0, 0, 0, 0, 0, 0, 0);
    // R9: same-cycle read sees old data, then new
    cyc("R9", 7'd20, 2'd0, 10'd0, 7'd20, 2'd1, 10'd0, 1, 1, 0, 7'd20, 2'd0, 10'd0, 64'h0102_0304_0506_0708);
    cyc("R9", 7'd20, 2'd0, 10'd0, 7'd20, 2'd1, 10'd0, 1, 0, 0, 7'd20, 2'd2, 10'd0, 64'hFFFF);
    cyc("R9", 7'd20, 2'd0, 10'd0, 7'd21, 2'd1, 10'd0, 0, 0, 0, 0, 0, 0, 0);
    // R8: random mixed traffic on both ports
    for (int n = 0; n < 4000; n++) begin
      logic [6:0] r0 = 7'($urandom), r1 = 7'($urandom), rw = 7'($urandom);
      logic [9:0] o0 = 10'($urandom % 24), o1 = 10'($urandom % 24), ow = 10'($urandom % 24);
      if (($urandom % 8) == 0) rw = 7'(120 + $urandom % 8);
      cyc("R8", r0, 2'($urandom), o0, r1, 2'($urandom), o1,
          bit'($urandom % 4 != 0), bit'($urandom % 4 != 0), bit'($urandom),
          rw, 2'($urandom), ow, {$urandom, $urandom});
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule